// File: doc/BRIEF.md
# Charge-Balancing Modulator Phase Sequencer

This block sequences a first-order charge-balancing sigma-delta temperature front-end. It steps through the integration cycles for each bitstream bit. It drives the two bipolar-core enables, a one-hot choice of the unit current source that carries the small collector current, and a ratio-swap line. It also drives two non-overlapping integrator phases, the integrator reset and the comparator strobe. After each bit it takes the comparator decision, which selects the kind of integration for the following bit.

A bit of value 0 integrates the PTAT difference voltage over two integration cycles. In the first cycle transistor 1 carries the large current. In the second the ratio is swapped, which cancels the mismatch between the two transistors. The unit source rotates once per completed zero-bit, so source mismatch averages out. A bit of value 1 integrates one base-emitter voltage with only one transistor enabled. The enabled transistor alternates on successive one-bits, so the common-mode charge cancels. Phase lengths are clock counts taken from two configuration inputs. The long count is used when an input swings between zero and a full junction voltage, and the short count when it moves between the two junction voltages. A conversion resets the integrator, emits a fixed number of bits and then pulses a completion flag.

Top module: `cb_phase_seq`

## Requirements
- R1: After reset and while idle, every phase, enable, select, strobe, valid, busy and done output is 0, and the comparator input has no effect.
- R2: A start pulse while idle raises `int_rst` for exactly one clock, the next clock has `phi1` high, and the first bit of every conversion is 0.
- R3: `phi1` and `phi2` are never high together; every phase is followed by exactly one clock with both low.
- R4: Each phase lasts `t_long` clocks during a one-bit and `t_short` clocks during a zero-bit; a length of 0 behaves as 1.
- R5: A zero-bit runs two integration cycles (phi1, gap, phi2, gap) with `en1` and `en2` both high, `swap`=0 in the first and `swap`=1 in the second.
- R6: During a zero-bit `src_sel` is one-hot with bit index p, where p is 0 at start and advances by one modulo N_SRC after each completed zero-bit; otherwise `src_sel` is 0.
- R7: A one-bit runs one integration cycle with exactly one enable high: `en2` for the first one-bit of a conversion, then alternating to `en1` and back on each following one-bit.
- R8: In the gap clock after the last `phi2` of a bit, `cmp_strobe` and `bit_valid` are high and `bit_out` equals that bit; `cmp_in` sampled at that clock's end is the next bit.
- R9: After NBITS bits, `done` is high for one clock on the clock after the last `bit_valid`, and `busy` is 0 from then on.
- R10: A start pulse during a conversion is ignored; the conversion still emits exactly NBITS bits on the unchanged schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion start pulse |
| cmp_in | input | 1 | Comparator decision |
| t_short | input | CNT_W | Phase length in clocks for difference-voltage bits |
| t_long | input | CNT_W | Phase length in clocks for junction-voltage bits |
| en1 | output | 1 | Bias enable, transistor 1 |
| en2 | output | 1 | Bias enable, transistor 2 |
| src_sel | output | N_SRC | One-hot unit-source select |
| swap | output | 1 | Current ratio swapped (transistor 2 large) |
| phi1 | output | 1 | Integrator sampling phase |
| phi2 | output | 1 | Integrator transfer phase |
| int_rst | output | 1 | Integrator reset |
| cmp_strobe | output | 1 | Comparator sample strobe |
| bit_out | output | 1 | Bitstream bit |
| bit_valid | output | 1 | Bitstream bit valid |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion complete pulse |

## Verification
A wrong state in the sequencer shows up at the ports within one phase. A stuck sub-cycle flag shows as a missing or extra swapped cycle. A bad rotation pointer gives the wrong one-hot index on the next zero-bit. A missed polarity toggle enables the wrong transistor on the next one-bit. A bad length count moves every following edge. The bench therefore checks the output set on every clock of each conversion against a schedule built from the requirements. A behavioural integrator closes the loop through `cmp_in`, so both kinds of bit and both polarities come up in mixed order.

// File: rtl/cb_phase_seq.sv
module cb_phase_seq #(
  parameter int N_SRC = 5,
  parameter int CNT_W = 16,
  parameter int NBITS = 6000,
  localparam int PTR_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int BC_W  = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_in,
  input  logic [CNT_W-1:0] t_short,
  input  logic [CNT_W-1:0] t_long,
  output logic             en1,
  output logic             en2,
  output logic [N_SRC-1:0] src_sel,
  output logic             swap,
  output logic             phi1,
  output logic             phi2,
  output logic             int_rst,
  output logic             cmp_strobe,
  output logic             bit_out,
  output logic             bit_valid,
  output logic             busy,
  output logic             done
);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_PH1, S_GAP1, S_PH2, S_GAP2} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             sub, cur_bit, pol, done_q;
  logic [PTR_W-1:0] ptr;
  logic [BC_W-1:0]  bitcnt;

  logic [CNT_W-1:0] len;
  logic [CNT_W:0]   cnt_nx;
  logic             ph_last, act, bit_end;

  assign len     = cur_bit ? t_long : t_short;
  assign cnt_nx  = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign ph_last = cnt_nx >= {1'b0, len};
  assign act     = (st == S_PH1) || (st == S_GAP1) || (st == S_PH2) || (st == S_GAP2);
  assign bit_end = (st == S_GAP2) && (cur_bit || sub);

  assign phi1       = (st == S_PH1);
  assign phi2       = (st == S_PH2);
  assign int_rst    = (st == S_RST);
  assign busy       = (st != S_IDLE);
  assign cmp_strobe = bit_end;
  assign bit_valid  = bit_end;
  assign bit_out    = bit_end && cur_bit;
  assign done       = done_q;
  assign en1        = act && (!cur_bit || pol);
  assign en2        = act && (!cur_bit || !pol);
  assign swap       = act && !cur_bit && sub;

  for (genvar i = 0; i < N_SRC; i++) begin : g_sel
    assign src_sel[i] = act && !cur_bit && (ptr == PTR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sub     <= 1'b0;
      cur_bit <= 1'b0;
      pol     <= 1'b0;
      ptr     <= '0;
      bitcnt  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_RST;
          cur_bit <= 1'b0;
          sub     <= 1'b0;
          pol     <= 1'b0;
          ptr     <= '0;
          bitcnt  <= '0;
        end
        S_RST: begin
          st  <= S_PH1;
          cnt <= '0;
        end
        S_PH1: if (ph_last) begin
          st  <= S_GAP1;
          cnt <= '0;
        end else cnt <= cnt_nx[CNT_W-1:0];
        S_GAP1: st <= S_PH2;
        S_PH2: if (ph_last) begin
          st  <= S_GAP2;
          cnt <= '0;
        end else cnt <= cnt_nx[CNT_W-1:0];
        S_GAP2: begin
          if (!bit_end) begin
            sub <= 1'b1;
            st  <= S_PH1;
          end else begin
            sub     <= 1'b0;
            cur_bit <= cmp_in;
            if (cur_bit) pol <= ~pol;
            else ptr <= (ptr == PTR_W'(N_SRC - 1)) ? '0 : ptr + 1'b1;
            if (bitcnt == BC_W'(NBITS - 1)) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              st     <= S_PH1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_dead_after_phi1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi1) |-> !phi2) else $error("phi2 directly after phi1");
  assert_dead_after_phi2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |-> !phi1) else $error("phi1 directly after phi2");
  assert_src_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_sel)) else $error("source select not one-hot");
  assert_sel_only_delta_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_sel) |-> (en1 && en2)) else $error("source selected outside zero-bit");
  assert_single_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phi1 && !(en1 && en2)) |-> (en1 ^ en2)) else $error("no enable during phase");
  assert_pol_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_out) |=> (pol != $past(pol))) else $error("polarity not toggled");
  assert_strobe_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> (!phi1 && !phi2)) else $error("strobe during phase");
  assert_rst_then_phi1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |=> phi1) else $error("no phi1 after integrator reset");
  assert_done_after_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bit_valid)) else $error("done without final bit");

endmodule

// File: tb/sim_cb_phase_seq.sv
module sim_cb_phase_seq;
  localparam int NS = 5;
  localparam int W  = 16;
  localparam int NB = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_in = 1'b0;
  logic [W-1:0] t_short = '0;
  logic [W-1:0] t_long = '0;
  logic en1, en2, swap, phi1, phi2, int_rst, cmp_strobe, bit_out, bit_valid, busy, done;
  logic [NS-1:0] src_sel;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  cb_phase_seq #(.N_SRC(NS), .CNT_W(W), .NBITS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .t_short(t_short), .t_long(t_long), .en1(en1), .en2(en2),
    .src_sel(src_sel), .swap(swap), .phi1(phi1), .phi2(phi2),
    .int_rst(int_rst), .cmp_strobe(cmp_strobe), .bit_out(bit_out),
    .bit_valid(bit_valid), .busy(busy), .done(done));

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, "phi1", phi1, 0);
    chk(req, "phi2", phi2, 0);
    chk(req, "en1/en2", {en1, en2}, 0);
    chk(req, "src_sel", src_sel, 0);
    chk(req, "int_rst/strobe/valid", {int_rst, cmp_strobe, bit_valid, bit_out}, 0);
    chk(req, "busy/done", {busy, done}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cmp_in = i[0];
      @(negedge clk);
      chk_idle("R1");
    end
  endtask

  task automatic run_conv(int ts, int tl, int dv, int vbe, bit mid_start);
    int acc = 0;
    int b = 0;
    int ptr = 0;
    int pol = 0;
    int nvalid = 0;
    t_short = W'(ts);
    t_long  = W'(tl);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "int_rst", int_rst, 1);
    chk("R2", "phi1 during reset", phi1, 0);
    for (int k = 0; k < NB; k++) begin
      int nsub = (b != 0) ? 1 : 2;
      int eff  = (b != 0) ? ((tl < 1) ? 1 : tl) : ((ts < 1) ? 1 : ts);
      int nb   = 0;
      for (int s = 0; s < nsub; s++) begin
        for (int ph = 0; ph < 2; ph++) begin
          for (int c = 0; c < eff; c++) begin
            @(negedge clk);
            start = (mid_start && k == 2 && s == 0 && ph == 0 && c == 0);
            chk("R4", "phi1", phi1, (ph == 0) ? 1 : 0);
            chk("R4", "phi2", phi2, (ph == 1) ? 1 : 0);
            if (b != 0) begin
              chk("R7", "en1", en1, pol);
              chk("R7", "en2", en2, 1 - pol);
              chk("R6", "src_sel idle on one-bit", src_sel, 0);
            end else begin
              chk("R5", "en1/en2", {en1, en2}, 3);
              chk("R5", "swap", swap, s);
              chk("R6", "src_sel", src_sel, 1 << ptr);
            end
            chk("R8", "strobe in phase", cmp_strobe, 0);
          end
          @(negedge clk);
          start = 1'b0;
          chk("R3", "gap phases", {phi1, phi2}, 0);
          if (ph == 1 && s == nsub - 1) begin
            chk("R8", "strobe", cmp_strobe, 1);
            chk("R8", "valid", bit_valid, 1);
            chk("R8", "bit_out", bit_out, b);
            if (k == 0) chk("R2", "first bit", bit_out, 0);
            if (bit_valid) nvalid++;
            if (b == 0) acc += 2 * dv; else acc -= vbe;
            nb = (acc > 0) ? 1 : 0;
            cmp_in = nb[0];
          end else begin
            chk("R8", "no strobe", {cmp_strobe, bit_valid}, 0);
          end
        end
      end
      if (b != 0) pol = 1 - pol; else ptr = (ptr + 1) % NS;
      b = nb;
    end
    @(negedge clk);
    chk("R9", "done", done, 1);
    chk("R9", "busy", busy, 0);
    @(negedge clk);
    chk("R9", "done pulse", done, 0);
    if (mid_start) chk("R10", "bits emitted", nvalid, NB);
  endtask

  task automatic t_after();
    for (int i = 0; i < 3; i++) begin
      cmp_in = ~cmp_in;
      @(negedge clk);
      chk_idle("R1");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R9 watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    t_reset();
    run_conv(3, 7, 1, 3, 1'b0);
    t_after();
    run_conv(0, 2, 1, 1, 1'b1);
    t_after();
    run_conv(2, 1, 2, 5, 1'b0);
    run_conv(1, 4, 1, 9, 1'b0);
    t_after();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule